// File: doc/BRIEF.md
# I3C Bus CCC Sequencing Tracker

This block sits beside an I3C controller and follows the stream of transaction events the controller issues: a start (or repeated start) with an address, a written byte, a read request and a stop. Each event is fanned out as a strobe to a parameterised array of target engines. The engines answer combinationally in the same cycle with an address match, a byte refusal and a read byte. The tracker folds those answers into one acknowledge for the bus and returns it, with any read data, one cycle after the event.

Alongside the fan-out, the tracker keeps the bus-level sequencing state. This state is made of three flags (broadcast address active, inside a common command, inside dynamic address assignment), the latched command code, and a mask of the targets taking part in the current transfer. The mask is rebuilt at every start. Dynamic address assignment (command code 0x07) survives repeated starts and ends only at a stop. A stop during assignment is delivered to every target, not only to those still taking part.

The event input is a valid-only stream with no back-pressure: one event is accepted on every cycle where `evt_valid` is high. Every accepted event produces exactly one response beat on `rsp_valid` in the next cycle, and the consumer must take it. Target engines must not derive their `tgt_match`, `tgt_refuse` or `tgt_rdata` answers from `tgt_strobe`.

Top module: `i3c_ccc_tracker`

## Requirements
- R1: After reset the broadcast, command and assignment flags are 0, no target participates, `bus_busy` is 0 and `rsp_valid` is 0.
- R2: Every cycle with `evt_valid` high produces `rsp_valid` high in the next cycle, and no other cycle does. Event kinds are 0 start, 1 write, 2 read, 3 stop.
- R3: A start to address 0x7E sets the broadcast flag. Outside assignment, it clears the command flag, makes all targets participate and is acknowledged.
- R4: A start to any other address clears the broadcast flag, keeps the command flag, and makes exactly the targets with `tgt_match` set participate. It is NACKed (`rsp_ack` 0) when none match.
- R5: During assignment, a start to 0x7E makes the matching targets participate and keeps the command and assignment flags. A start to any other address is NACKed and leaves no participant.
- R6: The first byte written after a broadcast start, with no command active, is latched into `ccc_code` and sets the command flag. If the byte is 0x07, the assignment flag is also set.
- R7: While a command is active, a refusal by a participating target NACKs the byte only when bit 7 of the command code is 1. Otherwise the byte is acknowledged.
- R8: Outside a command, a written byte is NACKed if any participating target refuses it. Refusals from targets that are not participating have no effect.
- R9: A read returns the byte of the lowest-indexed participating target and is acknowledged. With no participant, it returns 0xFF and is NACKed. Responses to other event kinds carry 0xFF.
- R10: A stop clears all three flags and the participation mask and is acknowledged. It strobes every target during assignment, and otherwise only the participants.
- R11: `bus_busy` is 1 exactly when at least one target participates.
- R12: A start strobes the targets that join. A write or read strobes the current participants. No strobe is raised without `evt_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_kind | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| evt_addr | input | 7 | Address for a start |
| evt_data | input | 8 | Byte for a write |
| tgt_strobe | output | N_TGT | Per-target event delivery |
| tgt_kind | output | 2 | Event kind passed to targets |
| tgt_addr | output | 7 | Address passed to targets |
| tgt_data | output | 8 | Byte passed to targets |
| tgt_match | input | N_TGT | Per-target address match for the current start |
| tgt_refuse | input | N_TGT | Per-target refusal of the current write byte |
| tgt_rdata | input | 8*N_TGT | Per-target read byte, target i at bits 8i+7:8i |
| flag_brd | output | 1 | Broadcast address active |
| flag_ccc | output | 1 | Inside a common command |
| flag_daa | output | 1 | Inside dynamic address assignment |
| ccc_code | output | 8 | Latched command code |
| bus_busy | output | 1 | Some target participates |
| rsp_valid | output | 1 | Response beat |
| rsp_ack | output | 1 | 1 acknowledge, 0 NACK |
| rsp_data | output | 8 | Read byte |

## Verification
Direct starts are swept over all sixteen match patterns of four targets. Each pattern is followed by reads and by writes under all sixteen refusal patterns. This separates the participant-only refusal rule and the lowest-index read selection from any scheme that looks at all targets. Broadcast commands with bit 7 clear and set, each under a full refusal, separate the two acknowledge rules. A repeated direct start inside a command confirms the code persists. An assignment sequence with repeated broadcast and direct starts, ending in a stop, separates the all-target stop from the participant-only stop used elsewhere.

// File: rtl/i3c_trk_pkg.sv
package i3c_trk_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  localparam logic [1:0] EV_START = 2'd0;
  localparam logic [1:0] EV_WRITE = 2'd1;
  localparam logic [1:0] EV_READ  = 2'd2;
  localparam logic [1:0] EV_STOP  = 2'd3;

  localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;
  localparam logic [BYTE_W-1:0] CODE_DAA   = 8'h07;
  localparam logic [BYTE_W-1:0] IDLE_BYTE  = 8'hFF;

  typedef struct packed {
    logic              brd;
    logic              ccc;
    logic              daa;
    logic [BYTE_W-1:0] code;
  } trk_flags_t;
endpackage

// File: rtl/i3c_trk_flags.sv
module i3c_trk_flags
  import i3c_trk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic              is_bcast,
  input  logic [BYTE_W-1:0] wr_byte,
  output trk_flags_t        flags_q,
  output logic              ccc_now,
  output logic [BYTE_W-1:0] code_now
);
  trk_flags_t flags_d;
  logic       opens_ccc;

  assign opens_ccc = ev_valid && (ev_kind == EV_WRITE) && flags_q.brd && !flags_q.ccc;
  assign ccc_now   = flags_q.ccc | opens_ccc;
  assign code_now  = opens_ccc ? wr_byte : flags_q.code;

  always_comb begin
    flags_d = flags_q;
    if (ev_valid) begin
      case (ev_kind)
        EV_START: begin
          flags_d.brd = is_bcast;
          if (is_bcast && !flags_q.daa) flags_d.ccc = 1'b0;
        end
        EV_WRITE: begin
          if (opens_ccc) begin
            flags_d.ccc  = 1'b1;
            flags_d.code = wr_byte;
            if (wr_byte == CODE_DAA) flags_d.daa = 1'b1;
          end
        end
        EV_STOP: begin
          flags_d.brd = 1'b0;
          flags_d.ccc = 1'b0;
          flags_d.daa = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/i3c_trk_part.sv
module i3c_trk_part
  import i3c_trk_pkg::*;
#(
  parameter int N_TGT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_valid,
  input  logic [1:0]              ev_kind,
  input  logic                    is_bcast,
  input  logic                    in_daa,
  input  logic [N_TGT-1:0]        match,
  input  logic [N_TGT-1:0]        refuse,
  input  logic [N_TGT*BYTE_W-1:0] rdata,
  output logic [N_TGT-1:0]        mask_q,
  output logic [N_TGT-1:0]        mask_join,
  output logic [N_TGT-1:0]        strobe,
  output logic                    refuse_any,
  output logic [BYTE_W-1:0]       first_byte
);
  localparam logic [N_TGT-1:0] ALL_TGT = {N_TGT{1'b1}};

  logic [BYTE_W-1:0] byte_of [N_TGT];

  for (genvar g = 0; g < N_TGT; g++) begin : g_unpack
    assign byte_of[g] = rdata[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (in_daa) mask_join = is_bcast ? match : '0;
    else        mask_join = is_bcast ? ALL_TGT : match;
  end

  always_comb begin
    strobe = '0;
    if (ev_valid) begin
      case (ev_kind)
        EV_START: strobe = mask_join;
        EV_STOP:  strobe = in_daa ? ALL_TGT : mask_q;
        default:  strobe = mask_q;
      endcase
    end
  end

  assign refuse_any = |(refuse & mask_q);

  always_comb begin
    first_byte = IDLE_BYTE;
    for (int i = N_TGT - 1; i >= 0; i--) begin
      if (mask_q[i]) first_byte = byte_of[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (ev_valid) begin
      if (ev_kind == EV_START)     mask_q <= mask_join;
      else if (ev_kind == EV_STOP) mask_q <= '0;
    end
  end
endmodule

// File: rtl/i3c_ccc_tracker.sv
module i3c_ccc_tracker
  import i3c_trk_pkg::*;
#(
  parameter int N_TGT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_valid,
  input  logic [1:0]              evt_kind,
  input  logic [ADDR_W-1:0]       evt_addr,
  input  logic [BYTE_W-1:0]       evt_data,
  output logic [N_TGT-1:0]        tgt_strobe,
  output logic [1:0]              tgt_kind,
  output logic [ADDR_W-1:0]       tgt_addr,
  output logic [BYTE_W-1:0]       tgt_data,
  input  logic [N_TGT-1:0]        tgt_match,
  input  logic [N_TGT-1:0]        tgt_refuse,
  input  logic [N_TGT*BYTE_W-1:0] tgt_rdata,
  output logic                    flag_brd,
  output logic                    flag_ccc,
  output logic                    flag_daa,
  output logic [BYTE_W-1:0]       ccc_code,
  output logic                    bus_busy,
  output logic                    rsp_valid,
  output logic                    rsp_ack,
  output logic [BYTE_W-1:0]       rsp_data
);
  trk_flags_t        flags_q;
  logic              is_bcast;
  logic              ccc_now;
  logic [BYTE_W-1:0] code_now;
  logic [N_TGT-1:0]  mask_q;
  logic [N_TGT-1:0]  mask_join;
  logic              refuse_any;
  logic [BYTE_W-1:0] first_byte;
  logic              ack_c;
  logic [BYTE_W-1:0] data_c;

  assign is_bcast = (evt_addr == BCAST_ADDR);

  i3c_trk_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (evt_valid),
    .ev_kind  (evt_kind),
    .is_bcast (is_bcast),
    .wr_byte  (evt_data),
    .flags_q  (flags_q),
    .ccc_now  (ccc_now),
    .code_now (code_now)
  );

  i3c_trk_part #(.N_TGT(N_TGT)) u_part (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (evt_valid),
    .ev_kind    (evt_kind),
    .is_bcast   (is_bcast),
    .in_daa     (flags_q.daa),
    .match      (tgt_match),
    .refuse     (tgt_refuse),
    .rdata      (tgt_rdata),
    .mask_q     (mask_q),
    .mask_join  (mask_join),
    .strobe     (tgt_strobe),
    .refuse_any (refuse_any),
    .first_byte (first_byte)
  );

  assign tgt_kind = evt_kind;
  assign tgt_addr = evt_addr;
  assign tgt_data = evt_data;

  always_comb begin
    data_c = IDLE_BYTE;
    case (evt_kind)
      EV_START: ack_c = |mask_join;
      EV_WRITE: ack_c = ccc_now ? !(refuse_any && code_now[BYTE_W-1]) : !refuse_any;
      EV_READ: begin
        ack_c  = |mask_q;
        data_c = first_byte;
      end
      default:  ack_c = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_data  <= IDLE_BYTE;
    end else begin
      rsp_valid <= evt_valid;
      if (evt_valid) begin
        rsp_ack  <= ack_c;
        rsp_data <= data_c;
      end
    end
  end

  assign flag_brd = flags_q.brd;
  assign flag_ccc = flags_q.ccc;
  assign flag_daa = flags_q.daa;
  assign ccc_code = flags_q.code;
  assign bus_busy = |mask_q;
endmodule

// File: rtl/i3c_ccc_tracker_chk.sv
module i3c_ccc_tracker_chk
  import i3c_trk_pkg::*;
#(
  parameter int N_TGT = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    evt_valid,
  input logic [1:0]              evt_kind,
  input logic [ADDR_W-1:0]       evt_addr,
  input logic [BYTE_W-1:0]       evt_data,
  input logic [N_TGT-1:0]        tgt_match,
  input logic [N_TGT-1:0]        tgt_strobe,
  input logic                    flag_brd,
  input logic                    flag_ccc,
  input logic                    flag_daa,
  input logic [BYTE_W-1:0]       ccc_code,
  input logic                    bus_busy,
  input logic                    rsp_valid,
  input logic                    rsp_ack,
  input logic [BYTE_W-1:0]       rsp_data
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> !rsp_valid);
  assert_bcast_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_START && evt_addr == BCAST_ADDR && !flag_daa)
      |=> (flag_brd && !flag_ccc && rsp_ack));
  assert_direct_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_START && evt_addr != BCAST_ADDR) |=> !flag_brd);
  assert_nack_nomatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_START && evt_addr != BCAST_ADDR && tgt_match == '0)
      |=> (!rsp_ack && !bus_busy));
  assert_daa_persists_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_START && flag_daa) |=> (flag_daa && flag_ccc));
  assert_code_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_WRITE && flag_brd && !flag_ccc)
      |=> (flag_ccc && ccc_code == $past(evt_data)));
  assert_daa_implies_ccc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_daa |-> flag_ccc);
  assert_bcast_ccc_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_WRITE && flag_ccc && !ccc_code[BYTE_W-1]) |=> rsp_ack);
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_READ && !bus_busy) |=> (rsp_data == IDLE_BYTE && !rsp_ack));
  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_STOP)
      |=> (!flag_brd && !flag_ccc && !flag_daa && !bus_busy && rsp_ack));
  assert_no_idle_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> (tgt_strobe == '0));
endmodule

bind i3c_ccc_tracker i3c_ccc_tracker_chk #(.N_TGT(N_TGT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_valid  (evt_valid),
  .evt_kind   (evt_kind),
  .evt_addr   (evt_addr),
  .evt_data   (evt_data),
  .tgt_match  (tgt_match),
  .tgt_strobe (tgt_strobe),
  .flag_brd   (flag_brd),
  .flag_ccc   (flag_ccc),
  .flag_daa   (flag_daa),
  .ccc_code   (ccc_code),
  .bus_busy   (bus_busy),
  .rsp_valid  (rsp_valid),
  .rsp_ack    (rsp_ack),
  .rsp_data   (rsp_data)
);

// File: tb/i3c_ccc_tracker_tb.sv
`timescale 1ns/1ps
module i3c_ccc_tracker_tb;
  localparam int NT = 4;
  localparam logic [1:0] K_START = 2'd0, K_WRITE = 2'd1, K_READ = 2'd2, K_STOP = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_valid = 1'b0;
  logic [1:0]    evt_kind = 2'd0;
  logic [6:0]    evt_addr = 7'd0;
  logic [7:0]    evt_data = 8'd0;
  logic [NT-1:0] tgt_strobe;
  logic [1:0]    tgt_kind;
  logic [6:0]    tgt_addr;
  logic [7:0]    tgt_data;
  logic [NT-1:0] tgt_match = '0;
  logic [NT-1:0] tgt_refuse = '0;
  logic [NT*8-1:0] tgt_rdata;
  logic flag_brd, flag_ccc, flag_daa, bus_busy, rsp_valid, rsp_ack;
  logic [7:0] ccc_code, rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [NT-1:0] got_strb;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NT; g++) begin : g_rd
    assign tgt_rdata[g*8 +: 8] = 8'h10 + 8'(g);
  end

  i3c_ccc_tracker #(.N_TGT(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_addr(evt_addr), .evt_data(evt_data), .tgt_strobe(tgt_strobe),
    .tgt_kind(tgt_kind), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .tgt_match(tgt_match), .tgt_refuse(tgt_refuse), .tgt_rdata(tgt_rdata),
    .flag_brd(flag_brd), .flag_ccc(flag_ccc), .flag_daa(flag_daa),
    .ccc_code(ccc_code), .bus_busy(bus_busy), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [6:0] a, input logic [7:0] d);
    evt_valid = 1'b1; evt_kind = k; evt_addr = a; evt_data = d;
    #1 got_strb = tgt_strobe;
    @(posedge clk);
    @(negedge clk);
    evt_valid = 1'b0;
    #1;
    check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [7:0] lowest_byte(input logic [NT-1:0] m);
    logic [7:0] r = 8'hFF;
    for (int i = NT - 1; i >= 0; i--) if (m[i]) r = 8'h10 + 8'(i);
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 flags", {29'd0, flag_brd, flag_ccc, flag_daa}, 32'd0);
    check("R1 busy", {31'd0, bus_busy}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R12 idle strobe", {28'd0, tgt_strobe}, 32'd0);
    #1;
    check("R2 no response when idle", {31'd0, rsp_valid}, 32'd0);

    // Direct-address sweep over all match patterns
    for (int m = 0; m < 16; m++) begin
      tgt_match = 4'(m);
      send(K_START, 7'h30, 8'h00);
      check("R12 start strobe", {28'd0, got_strb}, 32'(m));
      check("R4 start ack", {31'd0, rsp_ack}, 32'(m != 0));
      check("R4 brd cleared", {31'd0, flag_brd}, 32'd0);
      check("R11 busy", {31'd0, bus_busy}, 32'(m != 0));
      tgt_match = 4'(~m);
      send(K_READ, 7'h00, 8'h00);
      check("R12 read strobe", {28'd0, got_strb}, 32'(m));
      check("R9 read data", {24'd0, rsp_data}, {24'd0, lowest_byte(4'(m))});
      check("R9 read ack", {31'd0, rsp_ack}, 32'(m != 0));
      for (int r = 0; r < 16; r++) begin
        tgt_refuse = 4'(r);
        send(K_WRITE, 7'h00, 8'h55);
        check("R8 plain write ack", {31'd0, rsp_ack}, 32'((r & m) == 0));
        check("R9 write rsp byte", {24'd0, rsp_data}, 32'hFF);
      end
      tgt_refuse = '0;
      send(K_STOP, 7'h00, 8'h00);
      check("R10 stop strobe participants", {28'd0, got_strb}, 32'(m));
      check("R10 stop ack", {31'd0, rsp_ack}, 32'd1);
      check("R11 busy after stop", {31'd0, bus_busy}, 32'd0);
    end

    // Broadcast command with bit 7 clear, full refusal
    tgt_match = '0;
    send(K_START, 7'h7E, 8'h00);
    check("R3 bcast ack", {31'd0, rsp_ack}, 32'd1);
    check("R3 bcast strobe all", {28'd0, got_strb}, 32'hF);
    check("R3 brd set", {31'd0, flag_brd}, 32'd1);
    tgt_refuse = 4'hF;
    send(K_WRITE, 7'h00, 8'h01);
    check("R7 broadcast ccc refusal acked", {31'd0, rsp_ack}, 32'd1);
    check("R6 ccc set", {31'd0, flag_ccc}, 32'd1);
    check("R6 code latched", {24'd0, ccc_code}, 32'h01);
    check("R6 no daa", {31'd0, flag_daa}, 32'd0);
    send(K_WRITE, 7'h00, 8'h22);
    check("R7 later byte acked", {31'd0, rsp_ack}, 32'd1);
    check("R6 code unchanged", {24'd0, ccc_code}, 32'h01);
    tgt_refuse = '0;
    send(K_STOP, 7'h00, 8'h00);
    check("R10 flags clear", {29'd0, flag_brd, flag_ccc, flag_daa}, 32'd0);

    // Direct command (bit 7 set)
    send(K_START, 7'h7E, 8'h00);
    send(K_WRITE, 7'h00, 8'h9A);
    check("R6 direct code", {24'd0, ccc_code}, 32'h9A);
    tgt_match = 4'b0010;
    send(K_START, 7'h30, 8'h00);
    check("R4 ccc kept on direct start", {31'd0, flag_ccc}, 32'd1);
    check("R4 brd cleared", {31'd0, flag_brd}, 32'd0);
    tgt_refuse = 4'b0010;
    send(K_WRITE, 7'h00, 8'h44);
    check("R7 direct ccc refusal nacked", {31'd0, rsp_ack}, 32'd0);
    tgt_refuse = 4'b0001;
    send(K_WRITE, 7'h00, 8'h44);
    check("R8 non-participant refusal ignored", {31'd0, rsp_ack}, 32'd1);
    tgt_refuse = '0;
    send(K_START, 7'h7E, 8'h00);
    check("R3 bcast restart clears ccc", {31'd0, flag_ccc}, 32'd0);
    send(K_STOP, 7'h00, 8'h00);

    // Dynamic address assignment
    tgt_match = '0;
    send(K_START, 7'h7E, 8'h00);
    send(K_WRITE, 7'h00, 8'h07);
    check("R6 daa set", {30'd0, flag_daa, flag_ccc}, 32'd3);
    tgt_match = 4'b0101;
    send(K_START, 7'h7E, 8'h00);
    check("R5 daa bcast strobe", {28'd0, got_strb}, 32'h5);
    check("R5 daa bcast ack", {31'd0, rsp_ack}, 32'd1);
    check("R5 daa persists", {30'd0, flag_daa, flag_ccc}, 32'd3);
    send(K_READ, 7'h00, 8'h00);
    check("R9 daa read first", {24'd0, rsp_data}, 32'h10);
    tgt_match = 4'hF;
    send(K_START, 7'h30, 8'h00);
    check("R5 daa direct nack", {31'd0, rsp_ack}, 32'd0);
    check("R5 daa direct empty", {31'd0, bus_busy}, 32'd0);
    check("R5 daa still active", {31'd0, flag_daa}, 32'd1);
    tgt_match = 4'b0100;
    send(K_START, 7'h7E, 8'h00);
    check("R11 busy", {31'd0, bus_busy}, 32'd1);
    send(K_STOP, 7'h00, 8'h00);
    check("R10 daa stop strobes all", {28'd0, got_strb}, 32'hF);
    check("R10 daa cleared", {29'd0, flag_brd, flag_ccc, flag_daa}, 32'd0);
    tgt_match = '0;
    send(K_START, 7'h7E, 8'h00);
    check("R3 bcast after daa all", {28'd0, got_strb}, 32'hF);
    send(K_STOP, 7'h00, 8'h00);

    finish_up();
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule